// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external host read and write a bank of 32 eight-bit configuration registers over a four-signal serial link: an active-low select, a serial clock, and one or two data pins. Every transaction opens with a command byte. That byte sets the direction, the number of data bytes (one to four) and the first register address. The data bytes that follow go to or come from registers at falling addresses. The address steps down by one for each byte and wraps from 0 to 31.

A static mode input picks the pin arrangement. In three-wire mode the single data pin is shared, and the block drives it only while it returns read data. In four-wire mode the shared pin is input only and a separate output pin carries read data. The serial inputs are sampled by the block's own clock `clk`. They must already be synchronous to that clock and slow enough for edge detection, so the serial clock must be at most one eighth of `clk`.

Top module: `spi_regport`

## Requirements
- R1: A synchronous active-high `rst` sets all 32 registers to 0x00, and a read after reset returns 0x00 from every address.
- R2: While `cs_n` is low, `sdio_in` is sampled MSB first on each rising `sclk`. The first byte is the command: bit 7 is the direction (0 write, 1 read), bits 6:5 hold the data byte count minus one, and bits 4:0 hold the first register address.
- R3: In a write, each complete data byte, received MSB first, replaces the content of the register it is addressed to.
- R4: A transaction moves exactly count-minus-one plus one data bytes. Any further bytes before `cs_n` rises do not change any register.
- R5: The first data byte uses the command address. Each later byte uses the address one lower than the byte before it, and the address after 0 is 31.
- R6: In a read, each data bit is updated after a falling `sclk`, MSB first, and is valid at the next rising `sclk`. Bit 7 of the first addressed register is valid at the first rising edge after the command byte.
- R7: With `mode_3wire`=1, `sdio_oe` is high only during the data phase of a read. It is low during the command byte, during writes, and within one `clk` cycle after `cs_n` goes high.
- R8: With `mode_3wire`=0, read data appears on `sdo_out` with `sdo_oe` high during the same window as in R7, and `sdio_oe` stays low.
- R9: If `cs_n` rises before a byte is complete, the partial byte is discarded without any register write. The next transaction starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| mode_3wire | input | 1 | 1 = shared data pin, 0 = separate output pin |
| cs_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data from the host (shared pin input side) |
| sdio_out | output | 1 | Read data toward the shared pin |
| sdio_oe | output | 1 | Output enable of the shared pin |
| sdo_out | output | 1 | Read data on the dedicated output pin |
| sdo_oe | output | 1 | Output enable of the dedicated output pin |

## Verification
The hardest case to reach from the ports is a select that is withdrawn in the middle of a byte. The bit counter is then left partly advanced, and a design that keeps it would shift the next command byte out of alignment. The bench reaches this by clocking five bits of a write and raising `cs_n` early. It then issues a full write and read at once and checks both the untouched register and the correctly decoded next transaction. Wrap-around below address 0 and the bytes sent after the declared count are reached with bursts that start at address 1 or run past their length.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned LEN_W  = 2;
    localparam int unsigned NUM_REGS = 1 << ADDR_W;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // Command byte: direction, count minus one, first address (MSB to LSB)
    typedef struct packed {
        logic              is_read;
        logic [LEN_W-1:0]  cnt_m1;
        logic [ADDR_W-1:0] start;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [DATA_W-1:0] b);
        return cmd_t'(b);
    endfunction

endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
    import spi_regport_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         din,
    output logic         fall,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);
    localparam int unsigned CNT_W = $clog2(W);

    logic             sclk_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-2:0]     shreg;
    logic             rise;

    assign rise      = ~cs_n & sclk & ~sclk_q;
    assign fall      = ~cs_n & ~sclk & sclk_q;
    assign byte_val  = {shreg, din};
    assign byte_done = rise & (bit_cnt == CNT_W'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg   <= byte_val[W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R9: a withdrawn select leaves no partial bit count behind
    p_partial_dropped_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (bit_cnt == '0))
        else $error("partial byte count kept after select release");

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_regport_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          fall,
    input  logic          byte_done,
    input  logic [DW-1:0] byte_val,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          dout,
    output logic          rd_oe
);
    phase_e        phase;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] remain;
    logic [DW-1:0] tx_sh;
    logic          dout_q;
    logic          oe_q;
    cmd_t          cmd;

    assign cmd   = unpack_cmd(byte_val);
    assign raddr = (phase == PH_CMD) ? cmd.start : addr_q - 1'b1;
    assign we    = byte_done & (phase == PH_DATA) & ~rd_q;
    assign waddr = addr_q;
    assign wdata = byte_val;
    assign dout  = dout_q;
    assign rd_oe = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_CMD;
            rd_q   <= 1'b0;
            addr_q <= '0;
            remain <= '0;
            tx_sh  <= '0;
            dout_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (cs_n) begin
            phase <= PH_CMD;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (phase == PH_DATA) & rd_q;
            if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        rd_q   <= cmd.is_read;
                        addr_q <= cmd.start;
                        remain <= cmd.cnt_m1;
                        tx_sh  <= rdata;
                        phase  <= PH_DATA;
                    end
                    PH_DATA: begin
                        addr_q <= addr_q - 1'b1;
                        tx_sh  <= rdata;
                        if (remain == '0) phase <= PH_DONE;
                        else              remain <= remain - 1'b1;
                    end
                    default: ;
                endcase
            end else if (fall) begin
                dout_q <= tx_sh[DW-1];
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
            end
        end
    end

    // R5: each completed data byte moves the address down by one, wrapping
    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == PH_DATA && !cs_n) |=> (addr_q == $past(addr_q) - 1'b1))
        else $error("address did not step down");

    // R4: once the declared count is used up, no write is issued
    p_no_write_after_count_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |-> !we)
        else $error("write after burst end");

    // R7: output enable drops one cycle after select release
    p_oe_release_r7: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !oe_q)
        else $error("output still enabled after select release");

    // R7: output enable only follows a read command
    p_oe_read_only_r7: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> rd_q)
        else $error("output enabled in a write");

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regport_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    localparam int unsigned N = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                 q <= '0;
            else if (we && waddr == AW'(g))          q <= wdata;
        end
        assign cells[g] = q;
    end

    assign rdata = cells[raddr];

    // R3: a write strobe lands its byte in the addressed cell
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        we |=> (cells[$past(waddr)] == $past(wdata)))
        else $error("written byte not stored");

    // R1: reset clears the cells at both ends of the bank
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (cells[0] == '0 && cells[N-1] == '0))
        else $error("reset left a register set");

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_3wire,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe,
    output logic sdo_out,
    output logic sdo_oe
);
    logic          fall, byte_done, we, dout, rd_oe;
    logic [DW-1:0] byte_val, rdata, wdata;
    logic [AW-1:0] raddr, waddr;

    spi_bit_shifter #(.W(DW)) u_shift (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(sdio_in),
        .fall(fall), .byte_done(byte_done), .byte_val(byte_val)
    );

    spi_cmd_seq #(.AW(AW), .DW(DW), .LW(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .fall(fall),
        .byte_done(byte_done), .byte_val(byte_val), .rdata(rdata),
        .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata),
        .dout(dout), .rd_oe(rd_oe)
    );

    spi_reg_bank #(.AW(AW), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    assign sdio_out = dout;
    assign sdo_out  = dout;
    assign sdio_oe  = rd_oe & mode_3wire;
    assign sdo_oe   = rd_oe & ~mode_3wire;

    // R7/R8: a pin is only driven when the previous cycle had the select low
    p_drive_needs_select_r8: assert property (@(posedge clk) disable iff (rst)
        (sdio_oe || sdo_oe) |-> $past(!cs_n))
        else $error("pin driven without select");

endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_3wire = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] model [32];

    always #4 clk = ~clk;

    spi_regport i_spi_regport (
        .clk(clk), .rst(rst), .mode_3wire(mode_3wire), .cs_n(cs_n),
        .sclk(sclk), .sdio_in(sdio_in), .sdio_out(sdio_out),
        .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bit: drive while sclk low, sample output just before the rising edge
    task automatic clk_bit(input logic b, output logic r, output logic oe, output logic other_oe);
        sdio_in = b;
        repeat (HALF) @(negedge clk);
        r        = mode_3wire ? sdio_out : sdo_out;
        oe       = mode_3wire ? sdio_oe  : sdo_oe;
        other_oe = mode_3wire ? sdo_oe   : sdio_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic rw, input logic [1:0] nm1, input logic [4:0] a,
                        input int nbytes, input logic [47:0] wd,
                        output logic [31:0] rdv, output logic oe_cmd, output logic oe_data,
                        output logic bad_pin);
        logic [7:0] cmd;
        logic r, oe, other;
        cmd = {rw, nm1, a};
        rdv = '0; oe_cmd = 1'b0; oe_data = 1'b1; bad_pin = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(cmd[i], r, oe, other);
            oe_cmd |= oe; bad_pin |= other;
        end
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] rb;
            for (int i = 7; i >= 0; i--) begin
                clk_bit(wd[47 - 8*k - (7 - i)], r, oe, other);
                rb[i] = r;
                bad_pin |= other;
                if (k <= int'(nm1)) oe_data &= oe;
            end
            if (k < 4) rdv = {rdv[23:0], rb};
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] nm1, input logic [4:0] a, input int nbytes, input logic [47:0] wd);
        logic [31:0] d; logic o1, o2, bp;
        xfer(1'b0, nm1, a, nbytes, wd, d, o1, o2, bp);
        chk("R7 no drive during write", {30'd0, o1, bp}, 32'd0);
        for (int k = 0; k <= int'(nm1); k++) model[5'(int'(a) - k)] = wd[47 - 8*k -: 8];
    endtask

    function automatic logic [31:0] expect_rd(input logic [1:0] nm1, input logic [4:0] a);
        logic [31:0] e = '0;
        for (int k = 0; k <= int'(nm1); k++) e = {e[23:0], model[5'(int'(a) - k)]};
        return e;
    endfunction

    task automatic rd(input string req, input logic [1:0] nm1, input logic [4:0] a);
        logic [31:0] d; logic oc, od, bp;
        xfer(1'b1, nm1, a, int'(nm1) + 1, 48'd0, d, oc, od, bp);
        chk(req, d, expect_rd(nm1, a));
        chk("R7/R8 enable only in data phase on selected pin", {29'd0, oc, od, bp}, 32'd2);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R7 reset idle enables", {30'd0, sdio_oe, sdo_oe}, 32'd0);
        for (int s = 31; s >= 3; s -= 4) rd("R1 cleared after reset", 2'd3, 5'(s));
    endtask

    task automatic t_single();
        wr(2'd0, 5'd5, 1, {8'hA5, 40'd0});
        rd("R2 R3 single write read", 2'd0, 5'd5);
        rd("R6 neighbour untouched", 2'd2, 5'd6);
    endtask

    task automatic t_burst();
        wr(2'd3, 5'd20, 4, {8'h11, 8'h22, 8'h33, 8'h44, 16'd0});
        rd("R5 R6 burst read descending", 2'd3, 5'd20);
        rd("R5 single at lowest burst address", 2'd0, 5'd17);
    endtask

    task automatic t_wrap();
        wr(2'd2, 5'd1, 3, {8'h5A, 8'h6B, 8'h7C, 24'd0});
        rd("R5 wrap reg 0", 2'd0, 5'd0);
        rd("R5 wrap reg 31", 2'd0, 5'd31);
        rd("R5 read burst across wrap", 2'd2, 5'd1);
    endtask

    task automatic t_overrun();
        wr(2'd1, 5'd10, 4, {8'hC1, 8'hC2, 8'hEE, 8'hFF, 16'd0});
        rd("R4 extra bytes ignored", 2'd3, 5'd10);
    endtask

    task automatic t_partial();
        logic r, oe, ot;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 0; i--) clk_bit(i[0] ? 1'b0 : 1'b0, r, oe, ot); // write cmd, count 1, addr 0
        for (int i = 0; i < 5; i++) clk_bit(1'b1, r, oe, ot);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        rd("R9 partial byte discarded", 2'd0, 5'd0);
        wr(2'd0, 5'd12, 1, {8'h3C, 40'd0});
        rd("R9 next transaction realigned", 2'd1, 5'd12);
    endtask

    task automatic t_four_wire();
        mode_3wire = 1'b0;
        wr(2'd1, 5'd25, 2, {8'h96, 8'h69, 32'd0});
        rd("R8 read via dedicated pin", 2'd1, 5'd25);
        mode_3wire = 1'b1;
        rd("R7 back to shared pin", 2'd1, 5'd25);
    endtask

    task automatic t_release();
        @(negedge clk);
        chk("R7 released while idle", {30'd0, sdio_oe, sdo_oe}, 32'd0);
    endtask

    task automatic t_reset_again();
        do_reset();
        rd("R1 cleared after second reset", 2'd3, 5'd20);
        rd("R1 cleared wrap area", 2'd1, 5'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL all-requirements watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_single();
        t_burst();
        t_wrap();
        t_overrun();
        t_partial();
        t_four_wire();
        t_release();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule